// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation analog-to-digital converter. It holds a 3-bit clock-select field, picks either a power-of-two division of the system clock or a separate free-running RC clock input as the conversion clock, and runs one conversion each time software raises the GO bit. The comparator, the trial DAC and the sample capacitor are external. The block drives the DAC with the current trial code, reads the comparator once per conversion clock period, and controls the capacitor connection.

A conversion lasts eleven conversion clock periods. In the first period the capacitor is cut off from the input. Each of the next ten periods settles one result bit, starting at the most significant. On the system clock cycle after the last bit, the block latches the result, drops GO, raises the sticky interrupt flag and reconnects the capacitor. If software drops GO partway through, the conversion stops with no result and no flag. The RC source is the only choice that keeps running when the system clock is stopped. Here it enters through a two-flop synchronizer and a rising-edge detector.

Top module: `sar_seq`

## Requirements
- R1: Select codes map to system clock divisors as follows: 000 gives /2, 100 gives /4, 001 gives /8, 101 gives /16, 010 gives /32 and 110 gives /64. A go_set_i pulse is sampled at edge 0. With divisor D, flag_o first reads 1 after edge 11*D+1.
- R2: Any select code with sel[1:0]==2'b11 steps the conversion only on rising edges of rc_clk_i. While rc_clk_i is held still, the conversion does not advance.
- R3: A conversion starts with dac_o = 10'h200. At each bit step the current trial bit is kept when cmp_i is 1 and cleared when it is 0, and the next lower bit becomes the new trial. Bits are settled from bit 9 down to bit 0.
- R4: From the edge that samples go_set_i until the conversion ends, sample_o is 0 (capacitor disconnected). The first conversion clock period settles no bit, and the next ten each settle one bit.
- R5: On the cycle after bit 0 is settled, result_o takes the converted code, go_o falls to 0, flag_o rises to 1 and sample_o returns to 1.
- R6: go_set_i has no effect while go_o is 1. The conversion in progress keeps its timing and its result.
- R7: go_clr_i during a conversion aborts it on the next edge. go_o becomes 0 and sample_o becomes 1, result_o keeps its old value and flag_o is not set.
- R8: A select write (sel_wr_i) is dropped while go_o is 1, and sel_o keeps its value. When go_o is 0 the write takes effect on the next edge.
- R9: flag_o stays 1 until flag_clr_i is pulsed. If completion and flag_clr_i occur in the same cycle, the set wins.
- R10: After reset, go_o=0, flag_o=0, sample_o=1, result_o=0 and sel_o=3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rc_clk_i | input | 1 | Asynchronous internal RC clock |
| sel_wr_i | input | 1 | Write strobe for the clock-select field |
| sel_wdata_i | input | 3 | Clock-select write data |
| go_set_i | input | 1 | Software sets GO (start) |
| go_clr_i | input | 1 | Software clears GO (abort) |
| flag_clr_i | input | 1 | Software clears the interrupt flag |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| sel_o | output | 3 | Current clock-select field |
| go_o | output | 1 | GO bit; 1 while converting |
| flag_o | output | 1 | Sticky conversion-complete interrupt flag |
| sample_o | output | 1 | 1 connects the sample capacitor to the input |
| dac_o | output | 10 | Trial code to the DAC |
| result_o | output | 10 | Result register |

## Verification
Assertions check every cycle that the divided-clock step pulse is never two cycles long, that the RC edge pulse is never two cycles long, and that the capacitor stays disconnected during a conversion. They also check that the trial register holds still between steps, that the completion cycle is always followed by flag set, GO clear and reconnect, that an abort leaves the result untouched, that the select field is frozen while GO is 1, and that the flag is sticky. Only the bench's scenarios can show the full behaviour. These include the exact cycle count for each divisor code, the converted code matching the modelled input across random and extreme values, conversions that stall while the RC clock is stopped, and dropped starts and select writes that leave timing and result unchanged.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int NBITS  = 10;
  localparam int PRE_W  = 6;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_DONE} sar_state_e;

  function automatic logic sel_is_rc(input logic [SEL_W-1:0] s);
    return &s[1:0];
  endfunction

  // terminal count of the prescaler: divisor is 2^(1 + 2*s[1:0] + s[2])
  function automatic logic [PRE_W-1:0] div_limit(input logic [SEL_W-1:0] s);
    int n;
    n = 1 + 2 * int'(s[1:0]) + int'(s[2]);
    if (&s[1:0]) n = 1;
    return PRE_W'((1 << n) - 1);
  endfunction
endpackage

// File: rtl/sar_clk_gen.sv
module sar_clk_gen
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rc_clk_i,
  output logic             step_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rc_prev_q;
  logic                   rc_pulse;
  logic [PRE_W-1:0]       pre_q;
  logic [PRE_W-1:0]       limit;
  logic                   div_pulse;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= rc_clk_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], rc_clk_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rc_prev_q <= 1'b0;
    else         rc_prev_q <= sync_q[SYNC_STAGES-1];

  assign rc_pulse  = sync_q[SYNC_STAGES-1] & ~rc_prev_q;
  assign limit     = div_limit(sel_i);
  assign div_pulse = run_i && (pre_q == limit);

  // prescaler restarts at every conversion so period 1 begins on the GO edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        pre_q <= '0;
    else if (!run_i)    pre_q <= '0;
    else if (div_pulse) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;

  assign step_o = run_i && (sel_is_rc(sel_i) ? rc_pulse : div_pulse);

  AST_DIV_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse |=> !div_pulse); // R1
  AST_RC_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_pulse |=> !rc_pulse); // R2
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int N = NBITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         cmp_i,
  input  logic         go_set_i,
  input  logic         go_clr_i,
  input  logic         flag_clr_i,
  output logic         run_o,
  output logic         go_o,
  output logic         flag_o,
  output logic         sample_o,
  output logic [N-1:0] dac_o,
  output logic [N-1:0] result_o
);
  localparam int CNT_W = $clog2(N + 1);
  localparam logic [N-1:0] TRIAL0 = N'(1) << (N - 1);

  sar_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N-1:0]     sar_q, sar_nxt, result_q;
  logic             go_q, flag_q, sample_q;
  int               bit_idx;

  assign bit_idx = N - int'(cnt_q);

  always_comb begin
    sar_nxt = sar_q;
    for (int i = 0; i < N; i++) begin
      if (i == bit_idx)     sar_nxt[i] = cmp_i;
      if (i + 1 == bit_idx) sar_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
      go_q     <= 1'b0;
      flag_q   <= 1'b0;
      sample_q <= 1'b1;
    end else begin
      if (flag_clr_i) flag_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_set_i && !go_clr_i) begin
          state_q  <= ST_CONV;
          go_q     <= 1'b1;
          sample_q <= 1'b0;
          sar_q    <= TRIAL0;
          cnt_q    <= '0;
        end
        ST_CONV: if (go_clr_i) begin
          state_q  <= ST_IDLE;
          go_q     <= 1'b0;
          sample_q <= 1'b1;
        end else if (step_i) begin
          if (cnt_q == '0) cnt_q <= CNT_W'(1);  // end of disconnect period
          else begin
            sar_q <= sar_nxt;
            if (cnt_q == CNT_W'(N)) state_q <= ST_DONE;
            else                    cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_DONE: begin
          state_q  <= ST_IDLE;
          result_q <= sar_q;
          go_q     <= 1'b0;
          flag_q   <= 1'b1;
          sample_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q == ST_CONV);
  assign go_o     = go_q;
  assign flag_o   = flag_q;
  assign sample_o = sample_q;
  assign dac_o    = sar_q;
  assign result_o = result_q;

  AST_START_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_q) |-> (sar_q == TRIAL0)); // R3
  AST_CAP_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> !sample_q); // R4
  AST_DONE_ACTIONS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (flag_q && !go_q && sample_q)); // R5
  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !step_i && !go_clr_i) |=> ($stable(sar_q) && $stable(cnt_q))); // R6
  AST_ABORT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && go_clr_i) |=> ($stable(result_q) && !go_q && sample_q)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q); // R9
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rc_clk_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic             flag_clr_i,
  input  logic             cmp_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             go_o,
  output logic             flag_o,
  output logic             sample_o,
  output logic [NBITS-1:0] dac_o,
  output logic [NBITS-1:0] result_o
);
  logic [SEL_W-1:0] sel_q;
  logic             run, step, go;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              sel_q <= '0;
    else if (sel_wr_i && !go) sel_q <= sel_wdata_i;

  sar_clk_gen #(.SYNC_STAGES(2)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sel_i    (sel_q),
    .rc_clk_i (rc_clk_i),
    .step_o   (step)
  );

  sar_core #(.N(NBITS)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .cmp_i      (cmp_i),
    .go_set_i   (go_set_i),
    .go_clr_i   (go_clr_i),
    .flag_clr_i (flag_clr_i),
    .run_o      (run),
    .go_o       (go),
    .flag_o     (flag_o),
    .sample_o   (sample_o),
    .dac_o      (dac_o),
    .result_o   (result_o)
  );

  assign sel_o = sel_q;
  assign go_o  = go;

  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> $stable(sel_q)); // R8
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rc_clk = 1'b0;
  logic       sel_wr = 1'b0;
  logic [2:0] sel_wdata = '0;
  logic       go_set = 1'b0, go_clr = 1'b0, flag_clr = 1'b0;
  logic       cmp;
  logic [2:0] sel;
  logic       go, flag, sample;
  logic [9:0] dac, result;
  logic [9:0] vin = '0;
  logic       rc_en = 1'b0;
  int         checks = 0, fails = 0, cycles = 0, rc_cnt = 0;

  always #4 clk = ~clk;

  sar_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .rc_clk_i(rc_clk), .sel_wr_i(sel_wr),
    .sel_wdata_i(sel_wdata), .go_set_i(go_set), .go_clr_i(go_clr),
    .flag_clr_i(flag_clr), .cmp_i(cmp), .sel_o(sel), .go_o(go),
    .flag_o(flag), .sample_o(sample), .dac_o(dac), .result_o(result)
  );

  assign cmp = (vin >= dac);  // comparator model

  // slow RC clock: toggles every 3 system cycles while enabled
  always @(negedge clk) if (rc_en) begin
    rc_cnt <= rc_cnt + 1;
    if (rc_cnt % 3 == 2) rc_clk <= ~rc_clk;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'b000: return 2;
      3'b100: return 4;
      3'b001: return 8;
      3'b101: return 16;
      3'b010: return 32;
      3'b110: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic write_sel(input logic [2:0] s);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = s;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // divided-clock conversion; optionally pokes GO and select mid-run
  task automatic run_div(input logic [2:0] s, input logic [9:0] v, input bit poke);
    int n, d;
    d = divisor(s);
    write_sel(s);
    chk("R8 sel write idle", int'(sel), int'(s));
    vin = v;
    @(negedge clk); go_set = 1'b1;
    n = 0;
    do begin
      @(negedge clk); go_set = 1'b0; sel_wr = 1'b0;
      n++;
      if (n == 1) begin
        chk("R4 sample low", int'(sample), 0);
        chk("R3 first trial", int'(dac), 10'h200);
      end
      if (poke && n == 5) begin go_set = 1'b1; sel_wr = 1'b1; sel_wdata = ~s; end
    end while (!flag && n < 2000);
    chk("R1 completion cycle", n, 11 * d + 2);
    chk("R3 result", int'(result), int'(v));
    chk("R5 go cleared", int'(go), 0);
    chk("R5 sample reconnected", int'(sample), 1);
    if (poke) begin
      chk("R8 sel write dropped", int'(sel), int'(s));
      chk("R6 go_set ignored", n, 11 * d + 2);
    end
    clear_flag();
  endtask

  initial begin
    logic [2:0] codes [6];
    logic [9:0] prev;
    codes = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
    void'($urandom(32'd1847));
    repeat (3) @(negedge clk);
    chk("R10 go", int'(go), 0);
    chk("R10 flag", int'(flag), 0);
    chk("R10 sample", int'(sample), 1);
    chk("R10 result", int'(result), 0);
    chk("R10 sel", int'(sel), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: every divisor code, extreme inputs
    for (int i = 0; i < 6; i++) run_div(codes[i], (i % 2) ? 10'h3ff : 10'h000, 1'b0);
    run_div(3'b000, 10'h200, 1'b1);
    run_div(3'b100, 10'h1ff, 1'b1);
    // random
    for (int i = 0; i < 14; i++)
      run_div(codes[$urandom % 6], 10'($urandom), 1'($urandom));

    // R9: flag sticky, set wins over clear at completion
    run_div(3'b000, 10'h155, 1'b0);
    @(negedge clk); go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 flag sticky", int'(flag), 1);
    clear_flag();
    chk("R9 flag cleared", int'(flag), 0);

    // R7: abort keeps result, no flag
    prev = result;
    write_sel(3'b101);
    vin = ~prev;
    @(negedge clk); go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    repeat (30) @(negedge clk);
    go_clr = 1'b1;
    @(negedge clk); go_clr = 1'b0;
    chk("R7 go low after abort", int'(go), 0);
    chk("R7 sample after abort", int'(sample), 1);
    repeat (300) @(negedge clk);
    chk("R7 no flag", int'(flag), 0);
    chk("R7 result kept", int'(result), int'(prev));

    // R2: RC source, stalled then running
    for (int k = 0; k < 2; k++) begin
      int n;
      write_sel(k ? 3'b111 : 3'b011);
      vin = 10'($urandom);
      rc_en = 1'b0;
      @(negedge clk); go_set = 1'b1;
      @(negedge clk); go_set = 1'b0;
      repeat (300) @(negedge clk);
      chk("R2 stalled without rc edges", int'(flag), 0);
      chk("R2 still busy", int'(go), 1);
      rc_en = 1'b1;
      n = 0;
      while (!flag && n < 2000) begin @(negedge clk); n++; end
      chk("R2 rc result", int'(result), int'(vin));
      chk("R2 rc finish", int'(flag), 1);
      rc_en = 1'b0;
      clear_flag();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule